// File: doc/BRIEF.md
# Serial converter read controller

This block sits on the host side of a serial analog-to-digital converter and runs entirely from the system clock. A single-cycle start request drives the chip-select line low. The block then produces a divided serial clock for a frame of 14 or 16 periods, chosen per frame, and collects the bits the converter returns. At the end of the frame it raises chip select and delivers the conversion word together with a one-cycle strobe and a validity flag.

The converter sends four leading zeros ahead of the data, most significant bit first. The first of these zeros is already on the line when chip select falls. Each falling serial edge then moves the stream on by one bit. A parameter sets the edge the host samples on. When sampling on falling edges, falling edge k reads stream bit k. When sampling on rising edges, rising edge k reads stream bit k+1, so the first zero is skipped and the last data bit arrives at rising edge 15. In both cases the leading zeros are discarded. The host may also cut a frame short. A frame that ends before all 16 bit positions have been clocked out is reported as invalid. A quiet gap with chip select high always separates two frames.

Top module: `adc_read_master`

## Requirements
- R1: While reset is high and after it, until a start is accepted, chip select reads 1, the serial clock reads 1, busy reads 0 and the result strobe reads 0. The serial clock is high in every cycle in which chip select is high.
- R2: A start seen while idle drives chip select low on the next clock. The serial clock stays high for SCLK_HALF cycles and then toggles every SCLK_HALF cycles, and the first edge is a falling edge.
- R3: A frame contains 16 serial clock periods when long_frame was 1 at the accepted start, and 14 periods when it was 0. Chip select rises SCLK_HALF cycles after the last rising edge.
- R4: With falling-edge capture, falling edge k samples stream bit k. Stream bits 1 to 4 are zeros and bits 5 to 16 are the result, MSB first.
- R5: With rising-edge capture, rising edge k samples stream bit k+1. The result is still stream bits 5 to 16, with the last bit taken at rising edge 15.
- R6: rd_valid is high for exactly one cycle, in the cycle in which chip select returns high. rd_ok is 1 only when at least 16 falling serial edges occurred in that frame.
- R7: When rd_ok is 0 at the strobe, rd_data is all zeros.
- R8: abort held high during a frame raises chip select, with the serial clock high, on the next clock. abort has no effect outside a frame.
- R9: After chip select rises, it stays high for QUIET_CYC cycles, and any start seen in that time is dropped.
- R10: busy equals the inverse of chip select in every cycle.
- R11: A start seen while a frame is in progress is dropped and does not lengthen or restart the frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one conversion frame |
| abort | input | 1 | End the current frame at once |
| long_frame | input | 1 | 1 selects 16 serial clocks, 0 selects 14; taken at start |
| sdo | input | 1 | Serial data returned by the converter |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock, idles high |
| busy | output | 1 | High while a frame is in progress |
| rd_valid | output | 1 | One-cycle result strobe |
| rd_data | output | DATA_BITS | Conversion result without leading zeros |
| rd_ok | output | 1 | Result complete; 0 for a truncated frame |

## Verification
Three pairs of events can land in the same cycle. An abort can coincide with a serial edge the divider is about to make. A start can arrive in the last cycle of the quiet gap. A start can be held high across a frame end. The bench sweeps the abort instant over a window of consecutive cycles around the sixteenth falling edge, and it holds start high over several back-to-back frames. A cycle-level reference model predicts chip select, the serial clock, the strobe, the validity flag and the word for both capture variants. For every abort instant, the model decides whether the edge won and whether the frame counts as complete.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FRAME = 2'd1,
        ST_QUIET = 2'd2
    } rd_state_e;

    typedef struct packed {
        logic fall;
        logic rise;
    } edge_ev_t;

    localparam int LEAD_ZEROS   = 4;
    localparam int CLKS_SHORT   = 14;
    localparam int CLKS_LONG    = 16;

    function automatic logic [4:0] frame_clocks(input logic long_sel);
        return long_sel ? 5'(CLKS_LONG) : 5'(CLKS_SHORT);
    endfunction

endpackage

// File: rtl/adcrd_sclk_gen.sv
module adcrd_sclk_gen
    import adcrd_pkg::*;
#(
    parameter int SCLK_HALF = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [4:0] frame_n,
    output logic       sclk,
    output edge_ev_t   ev,
    output logic [4:0] falls,
    output logic       last_done
);
    localparam int HC_W = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
    localparam logic [HC_W-1:0] HC_END = HC_W'(SCLK_HALF - 1);

    logic [HC_W-1:0] hc;
    logic            tick;

    assign tick = run && (hc == HC_END);

    always_comb begin
        ev.fall   = tick && sclk && (falls != frame_n);
        ev.rise   = tick && !sclk;
        last_done = tick && sclk && (falls == frame_n);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            hc    <= '0;
            sclk  <= 1'b1;
            falls <= '0;
        end else if (tick) begin
            hc <= '0;
            if (ev.fall) begin
                sclk  <= 1'b0;
                falls <= falls + 5'd1;
            end else if (ev.rise) begin
                sclk <= 1'b1;
            end
        end else begin
            hc <= hc + 1'b1;
        end
    end
endmodule

// File: rtl/adcrd_capture.sv
module adcrd_capture
    import adcrd_pkg::*;
#(
    parameter int DATA_BITS    = 12,
    parameter int CAPTURE_RISE = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 edge_hit,
    input  logic [4:0]           falls,
    input  logic                 sdo,
    output logic [DATA_BITS-1:0] word
);
    localparam int STREAM = LEAD_ZEROS + DATA_BITS;

    logic in_window;

    generate
        if (CAPTURE_RISE != 0) begin : g_rise
            // rising edge k reads stream bit k+1; stop after bit STREAM
            assign in_window = (falls <= 5'(STREAM - 1));
        end else begin : g_fall
            // falling edge k reads stream bit k; falls holds k-1 here
            assign in_window = (falls < 5'(STREAM));
        end
    endgenerate

    // older bits shift out the top, so the leading zeros vanish
    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
        end else if (edge_hit && in_window) begin
            word <= {word[DATA_BITS-2:0], sdo};
        end
    end
endmodule

// File: rtl/adcrd_quiet_timer.sv
module adcrd_quiet_timer #(
    parameter int QUIET_CYC = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic expired
);
    localparam int QW = $clog2(QUIET_CYC + 1);
    localparam logic [QW-1:0] Q_END = QW'(QUIET_CYC - 1);

    logic [QW-1:0] cnt;

    assign expired = en && (cnt == Q_END);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/adc_read_master.sv
module adc_read_master
    import adcrd_pkg::*;
#(
    parameter int SCLK_HALF    = 2,
    parameter int DATA_BITS    = 12,
    parameter int CAPTURE_RISE = 0,
    parameter int QUIET_CYC    = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 abort,
    input  logic                 long_frame,
    input  logic                 sdo,
    output logic                 cs_n,
    output logic                 sclk,
    output logic                 busy,
    output logic                 rd_valid,
    output logic [DATA_BITS-1:0] rd_data,
    output logic                 rd_ok
);
    localparam int MIN_CLKS = LEAD_ZEROS + DATA_BITS;

    rd_state_e            state;
    logic [4:0]           frame_q;
    logic [4:0]           falls;
    edge_ev_t             ev;
    logic                 last_done;
    logic                 run;
    logic                 in_quiet;
    logic                 quiet_over;
    logic                 edge_hit;
    logic                 enough;
    logic [DATA_BITS-1:0] word;

    assign run      = (state == ST_FRAME) && !abort;
    assign in_quiet = (state == ST_QUIET);
    assign edge_hit = (CAPTURE_RISE != 0) ? ev.rise : ev.fall;
    assign enough   = (falls >= 5'(MIN_CLKS));
    assign cs_n     = (state != ST_FRAME);
    assign busy     = (state == ST_FRAME);

    adcrd_sclk_gen #(.SCLK_HALF(SCLK_HALF)) u_sclk (
        .clk(clk), .rst(rst), .run(run), .frame_n(frame_q),
        .sclk(sclk), .ev(ev), .falls(falls), .last_done(last_done)
    );

    adcrd_capture #(.DATA_BITS(DATA_BITS), .CAPTURE_RISE(CAPTURE_RISE)) u_cap (
        .clk(clk), .rst(rst), .edge_hit(edge_hit), .falls(falls),
        .sdo(sdo), .word(word)
    );

    adcrd_quiet_timer #(.QUIET_CYC(QUIET_CYC)) u_quiet (
        .clk(clk), .rst(rst), .en(in_quiet), .expired(quiet_over)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            frame_q  <= frame_clocks(1'b1);
            rd_valid <= 1'b0;
            rd_ok    <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state   <= ST_FRAME;
                        frame_q <= frame_clocks(long_frame);
                    end
                end
                ST_FRAME: begin
                    if (abort || last_done) begin
                        state    <= ST_QUIET;
                        rd_valid <= 1'b1;
                        rd_ok    <= enough;
                        rd_data  <= enough ? word : '0;
                    end
                end
                ST_QUIET: begin
                    if (quiet_over) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adc_read_master_chk.sv
module adc_read_master_chk #(
    parameter int DATA_BITS = 12
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 abort,
    input logic                 cs_n,
    input logic                 sclk,
    input logic                 busy,
    input logic                 rd_valid,
    input logic [DATA_BITS-1:0] rd_data,
    input logic                 rd_ok
);
    assert_sclk_idle_R1: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> sclk);

    assert_strobe_at_rise_R6: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $rose(cs_n));

    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    assert_invalid_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ok) |-> (rd_data == '0));

    assert_abort_ends_R8: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && abort) |=> (cs_n && sclk));

    assert_quiet_gap_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |=> cs_n);

    assert_busy_on_fall_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> busy);
endmodule

bind adc_read_master adc_read_master_chk #(.DATA_BITS(DATA_BITS)) u_chk (
    .clk(clk), .rst(rst), .abort(abort), .cs_n(cs_n), .sclk(sclk),
    .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data), .rd_ok(rd_ok)
);

// File: tb/adc_read_master_test.sv
`timescale 1ns/1ps
module adc_read_master_test;
    localparam int HALF  = 2;
    localparam int QUIET = 5;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, abort = 1'b0, long_frame = 1'b1;
    logic sdo_f, sdo_r;
    logic cs_f, sclk_f, busy_f, val_f, ok_f;
    logic cs_r, sclk_r, busy_r, val_r, ok_r;
    logic [11:0] data_f, data_r;
    logic [11:0] adc_val = 12'h000;
    int idx_f = 0, idx_r = 0;
    int vectors = 0, fails = 0, cyc = 0;
    bit started = 0;

    always #2.5 clk = ~clk;

    adc_read_master #(.SCLK_HALF(HALF), .DATA_BITS(12), .CAPTURE_RISE(0), .QUIET_CYC(QUIET)) uut (
        .clk(clk), .rst(rst), .start(start), .abort(abort), .long_frame(long_frame),
        .sdo(sdo_f), .cs_n(cs_f), .sclk(sclk_f), .busy(busy_f),
        .rd_valid(val_f), .rd_data(data_f), .rd_ok(ok_f));

    adc_read_master #(.SCLK_HALF(HALF), .DATA_BITS(12), .CAPTURE_RISE(1), .QUIET_CYC(QUIET)) uut_r (
        .clk(clk), .rst(rst), .start(start), .abort(abort), .long_frame(long_frame),
        .sdo(sdo_r), .cs_n(cs_r), .sclk(sclk_r), .busy(busy_r),
        .rd_valid(val_r), .rd_data(data_r), .rd_ok(ok_r));

    // converter model: 4 zeros, 12 data bits MSB first, zeros after
    function automatic logic stream_bit(input logic [11:0] v, input int k);
        if (k >= 5 && k <= 16) return v[16-k];
        return 1'b0;
    endfunction

    always @(negedge cs_f) idx_f = 1;
    always @(negedge sclk_f) if (!cs_f) idx_f = idx_f + 1;
    always @(negedge cs_r) idx_r = 1;
    always @(negedge sclk_r) if (!cs_r) idx_r = idx_r + 1;
    assign sdo_f = stream_bit(adc_val, idx_f);
    assign sdo_r = stream_bit(adc_val, idx_r);

    // reference model: 0 idle, 1 frame, 2 quiet
    int ms = 0, t = 0, q = 0, nclk = 16, hh = 0, ff = 0;
    bit m_valid = 0, m_ok = 0;
    logic [11:0] m_data = 12'h000;

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            ms = 0; m_valid = 0;
        end else begin
            m_valid = 0;
            case (ms)
                0: if (start) begin ms = 1; t = 0; nclk = long_frame ? 16 : 14; end
                1: begin
                    if (abort || t == HALF*(2*nclk+1)-1) begin
                        hh = t / HALF;
                        ff = (hh + 1) / 2;
                        if (ff > nclk) ff = nclk;
                        m_ok = (ff >= 16);
                        m_data = m_ok ? adc_val : 12'h000;
                        m_valid = 1; ms = 2; q = 0;
                    end else t = t + 1;
                end
                default: if (q == QUIET-1) ms = 0; else q = q + 1;
            endcase
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            logic e_cs, e_sclk;
            e_cs   = (ms != 1);
            e_sclk = (ms != 1) ? 1'b1 : (((t / HALF) % 2) == 0);
            if (rst) begin
                chk("R1 cs_n", {31'b0, cs_f}, 1);
                chk("R1 sclk", {31'b0, sclk_f}, 1);
                chk("R1 busy", {31'b0, busy_f}, 0);
                chk("R1 rd_valid", {31'b0, val_f}, 0);
            end else begin
                chk("R2 R3 R8 R9 R11 cs_n", {31'b0, cs_f}, {31'b0, e_cs});
                chk("R2 R3 R8 R9 R11 cs_n rise", {31'b0, cs_r}, {31'b0, e_cs});
                chk("R1 R2 R3 sclk", {31'b0, sclk_f}, {31'b0, e_sclk});
                chk("R1 R2 R3 sclk rise", {31'b0, sclk_r}, {31'b0, e_sclk});
                chk("R10 busy", {31'b0, busy_f}, {31'b0, ~e_cs});
                chk("R6 rd_valid", {31'b0, val_f}, {31'b0, m_valid});
                chk("R6 rd_valid rise", {31'b0, val_r}, {31'b0, m_valid});
                if (m_valid) begin
                    chk("R6 rd_ok", {31'b0, ok_f}, {31'b0, m_ok});
                    chk("R6 rd_ok rise", {31'b0, ok_r}, {31'b0, m_ok});
                    chk("R4 R7 rd_data falling", {20'b0, data_f}, {20'b0, m_data});
                    chk("R5 R7 rd_data rising", {20'b0, data_r}, {20'b0, m_data});
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog expired, actual=%0d expected<=100000 cycles", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic frame(input logic lf, input logic [11:0] v, input int abort_after);
        @(negedge clk);
        adc_val = v; long_frame = lf; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (abort_after > 0) begin
            repeat (abort_after) @(negedge clk);
            abort = 1'b1;
            @(negedge clk);
            abort = 1'b0;
        end
        repeat (90) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R4 R5: full frames with distinct words
        frame(1'b1, 12'hA5C, 0);
        frame(1'b1, 12'hFFF, 0);
        frame(1'b1, 12'h000, 0);
        frame(1'b1, 12'h801, 0);
        // R3 R7: short frame is truncated for a 12-bit word
        frame(1'b0, 12'h3F1, 0);
        // R8: early abort, then a sweep around the last falling edge
        frame(1'b1, 12'h5A5, 10);
        for (int a = 58; a < 68; a++) frame(1'b1, 12'hC3A, a);
        // R11: start pulse during a frame is dropped
        @(negedge clk); adc_val = 12'h1E7; long_frame = 1'b1; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (30) @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (80) @(negedge clk);
        // R8: abort while idle has no effect
        abort = 1'b1; repeat (3) @(negedge clk); abort = 1'b0;
        repeat (5) @(negedge clk);
        // R9: start held high across frame ends and quiet gaps
        adc_val = 12'h6B3; long_frame = 1'b1; start = 1'b1;
        repeat (250) @(negedge clk);
        start = 1'b0;
        repeat (100) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule